// File: doc/BRIEF.md
# Serial Transmitter with Priority Queue

This block is the transmit half of one asynchronous serial channel. Bytes written by the host go into a normal transmit queue, 255 bytes deep by default. A second, small queue of 32 bytes carries urgent bytes. A one-byte holding stage sits between the queues and the shift register. Whenever that stage is free it takes a byte from the urgent queue first, so urgent bytes overtake queued ones at the next character boundary. The shift register sends a start bit, seven or eight data bits (least significant first), an optional parity bit and one or two stop bits.

The bit clock comes from a fixed prescaler (divide by 10 by default) followed by a 16-bit divisor. One bit lasts PRESCALE × (divisor + 1) clock cycles. Line control covers these functions:
- a transmit enable that gates only refills from the normal queue;
- output flow control on the clear-to-send input;
- a software hold-off state with an override;
- break, which holds the line low;
- internal loopback;
- direct DTR and RTS levels, plus an RTS mode that follows line activity.

Status outputs report the normal queue fill level, the urgent queue level with a pending flag, and whether the queue and the shifting path are empty.

Top module: `uart_tx_prio`

## Requirements
- R1: After reset, txd is 1, tx_count is 0, prio_status is 0, and fifo_empty, shift_empty and drained are all 1.
- R2: A character on the line has these parts, in order:
  - a start bit of 0;
  - the data bits, least significant first: 8 bits when frame_cfg[0] is 1, else 7;
  - a parity bit, only when frame_cfg[2] is 1. It is even parity when frame_cfg[1] is 1, else odd;
  - the stop bits of 1: two when frame_cfg[3] is 1, else one.
- R3: Every bit lasts PRESCALE × (baud_div + 1) clock cycles, which is 10 × (baud_div + 1) with the default parameters.
- R4: A byte in the urgent queue is moved to the holding stage before any byte of the normal queue. A normal byte that is already in the holding stage is still sent first. prio_status[7] is 1 while the urgent queue is not empty, and prio_status[6:0] is its count.
- R5: When line_ctl[0] (transmit enable) is 0, no byte leaves the normal queue. Bytes already in the holding stage or the shift register are still sent. Urgent bytes are still sent.
- R6: When line_ctl[6] (flow control) is 1 and cts is 0, no new character starts. A character that has already started is completed.
- R7: A pulse on xoff_set stops new characters from starting. A pulse on xoff_override releases this hold.
- R8: When line_ctl[4] (break) is 1, txd is 0.
- R9: When line_ctl[3] (loopback) is 1, txd stays 1 and the serial stream appears on loop_out. Otherwise loop_out is 1.
- R10: dtr follows line_ctl[2]. rts follows line_ctl[1], unless line_ctl[5] (RTS toggle) is 1. In that case rts is 1 exactly while the holding stage or the shift register holds a character.
- R11: fifo_empty is 1 when the normal queue is empty. shift_empty is 1 when the holding stage and the shift register are both empty. drained is 1 only when both of these are 1.
- R12: A write to a full queue is dropped. The count stays at the depth, and the bytes already stored are sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_wr | input | 1 | Write strobe for the normal queue |
| fifo_wdata | input | 8 | Byte for the normal queue |
| prio_wr | input | 1 | Write strobe for the urgent queue |
| prio_wdata | input | 8 | Byte for the urgent queue |
| frame_cfg | input | 4 | Bit 3: two stop bits. Bit 2: parity on. Bit 1: even parity. Bit 0: eight data bits |
| line_ctl | input | 7 | Bit 6: CTS flow control. Bit 5: RTS toggle. Bit 4: break. Bit 3: loopback. Bit 2: DTR. Bit 1: RTS. Bit 0: transmit enable |
| baud_div | input | 16 | Bit-rate divisor |
| cts | input | 1 | Clear-to-send, 1 means asserted |
| xoff_set | input | 1 | Pulse that enters the software hold-off state |
| xoff_override | input | 1 | Pulse that leaves the software hold-off state |
| txd | output | 1 | Serial line |
| loop_out | output | 1 | Serial stream while in loopback |
| dtr | output | 1 | DTR output |
| rts | output | 1 | RTS output |
| tx_count | output | 8 | Bytes in the normal queue |
| prio_status | output | 8 | Bit 7: urgent data pending. Bits 6:0: urgent count |
| fifo_empty | output | 1 | Normal queue empty |
| shift_empty | output | 1 | Holding stage and shifter empty |
| drained | output | 1 | Queue and shifting path both empty |

## Verification
In a single cycle, the holding stage can see an urgent byte arrive, a normal byte waiting, and the shifter free its slot. The bench covers these collisions in two ways.

First, it writes one urgent byte and one normal byte in the same cycle into an idle channel. The decoded line must then show the urgent byte first.

Second, it writes urgent bytes while a normal byte is shifting and another normal byte already occupies the holding stage. The expected order is the shifting byte, then the held byte, then both urgent bytes, then the rest of the queue. A scoreboard compares every byte decoded from the line against this order.

// File: rtl/tx_pkg.sv
package tx_pkg;

    localparam int FRAME_W = 12;

    typedef struct packed {
        logic stop2;
        logic par_en;
        logic par_even;
        logic data8;
    } frame_cfg_t;

    typedef struct packed {
        logic cts_fc;
        logic rts_tog;
        logic brk;
        logic loopb;
        logic dtr;
        logic rts;
        logic tx_en;
    } line_ctl_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [3:0]         len;
    } frame_t;

    // Serialise one byte into a frame vector, LSB first (start bit at index 0).
    function automatic frame_t build_frame(frame_cfg_t cfg, logic [7:0] d);
        frame_t f;
        logic   par;
        int     n;
        f.bits = '1;
        f.bits[0] = 1'b0;
        n = 1;
        for (int i = 0; i < 8; i++) begin
            if (i < 7 || cfg.data8) begin
                f.bits[n] = d[i];
                n++;
            end
        end
        par = cfg.data8 ? ^d : ^d[6:0];
        if (!cfg.par_even) par = ~par;
        if (cfg.par_en) begin
            f.bits[n] = par;
            n++;
        end
        n = n + (cfg.stop2 ? 2 : 1);
        f.len = 4'(n);
        return f;
    endfunction

endpackage

// File: rtl/tx_queue.sv
module tx_queue #(
    parameter int DEPTH = 255,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_wr, do_rd;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (full && wr && !rd) |=> (count == $past(count))); // R12

endmodule

// File: rtl/tx_baud.sv
module tx_baud #(
    parameter int PRESCALE = 10,
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] div,
    output logic        tick
);
    logic [PW-1:0] pre;
    logic [15:0]   dcnt;
    logic          pre_wrap;

    assign pre_wrap = (pre == PW'(PRESCALE - 1));
    assign tick     = pre_wrap && (dcnt >= div);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre  <= '0;
            dcnt <= '0;
        end else if (pre_wrap) begin
            pre  <= '0;
            dcnt <= (dcnt >= div) ? '0 : dcnt + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start_ok,
    input  frame_cfg_t cfg,
    input  logic [7:0] hold_data,
    output logic       take,
    output logic       busy,
    output logic       serial
);
    logic [FRAME_W-1:0] sh;
    logic [3:0]         left;
    frame_t             nxt;

    assign nxt    = build_frame(cfg, hold_data);
    assign take   = tick && (left <= 4'd1) && start_ok;
    assign busy   = (left != '0);
    assign serial = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            left <= '0;
        end else if (tick) begin
            if (take) begin
                sh   <= nxt.bits;
                left <= nxt.len;
            end else if (busy) begin
                sh   <= {1'b1, sh[FRAME_W-1:1]};
                left <= left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_tx_prio.sv
module uart_tx_prio
    import tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 255,
    parameter int PRIO_DEPTH = 32,
    parameter int PRESCALE   = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fifo_wr,
    input  logic [7:0]  fifo_wdata,
    input  logic        prio_wr,
    input  logic [7:0]  prio_wdata,
    input  logic [3:0]  frame_cfg,
    input  logic [6:0]  line_ctl,
    input  logic [15:0] baud_div,
    input  logic        cts,
    input  logic        xoff_set,
    input  logic        xoff_override,
    output logic        txd,
    output logic        loop_out,
    output logic        dtr,
    output logic        rts,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] tx_count,
    output logic [7:0]  prio_status,
    output logic        fifo_empty,
    output logic        shift_empty,
    output logic        drained
);
    localparam int PCW = $clog2(PRIO_DEPTH + 1);

    line_ctl_t  ctl;
    frame_cfg_t cfg;
    assign ctl = line_ctl_t'(line_ctl);
    assign cfg = frame_cfg_t'(frame_cfg);

    logic [7:0]     fifo_rdata, prio_rdata, hold_data;
    logic [PCW-1:0] prio_count;
    logic           prio_empty, fifo_full, prio_full;
    logic           hold_full, pick_prio, pick_fifo;
    logic           tick, take, busy, serial, xoff_held, gate_ok;

    assign pick_prio = !hold_full && !prio_empty;
    assign pick_fifo = !hold_full && prio_empty && ctl.tx_en && !fifo_empty;

    tx_queue #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst(rst), .wr(fifo_wr), .wdata(fifo_wdata),
        .rd(pick_fifo), .rdata(fifo_rdata), .count(tx_count),
        .empty(fifo_empty), .full(fifo_full)
    );

    tx_queue #(.DEPTH(PRIO_DEPTH), .W(8)) u_prio (
        .clk(clk), .rst(rst), .wr(prio_wr), .wdata(prio_wdata),
        .rd(pick_prio), .rdata(prio_rdata), .count(prio_count),
        .empty(prio_empty), .full(prio_full)
    );

    tx_baud #(.PRESCALE(PRESCALE)) u_baud (
        .clk(clk), .rst(rst), .div(baud_div), .tick(tick)
    );

    // Holding stage: urgent queue wins whenever the slot is free.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (pick_prio || pick_fifo) begin
            hold_full <= 1'b1;
            hold_data <= pick_prio ? prio_rdata : fifo_rdata;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    // Software hold-off; override wins over a simultaneous set.
    always_ff @(posedge clk) begin
        if (rst)                xoff_held <= 1'b0;
        else if (xoff_override) xoff_held <= 1'b0;
        else if (xoff_set)      xoff_held <= 1'b1;
    end

    assign gate_ok = !(ctl.cts_fc && !cts) && !xoff_held;

    tx_shifter u_shift (
        .clk(clk), .rst(rst), .tick(tick), .start_ok(hold_full && gate_ok),
        .cfg(cfg), .hold_data(hold_data), .take(take), .busy(busy),
        .serial(serial)
    );

    logic line_bit;
    assign line_bit    = ctl.brk ? 1'b0 : serial;
    assign txd         = ctl.loopb ? 1'b1 : line_bit;
    assign loop_out    = ctl.loopb ? line_bit : 1'b1;
    assign dtr         = ctl.dtr;
    assign rts         = ctl.rts_tog ? (hold_full || busy) : ctl.rts;
    assign shift_empty = !hold_full && !busy;
    assign drained     = fifo_empty && shift_empty;
    assign prio_status = {!prio_empty, 7'(prio_count)};

    AST_NORMAL_AFTER_URGENT: assert property (@(posedge clk) disable iff (rst)
        (tx_count < $past(tx_count)) |-> $past(prio_empty)); // R4
    AST_DISABLED_QUEUE_STILL: assert property (@(posedge clk) disable iff (rst)
        (!line_ctl[0]) |=> (tx_count >= $past(tx_count))); // R5
    AST_CTS_NO_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!(line_ctl[6] && !cts))); // R6
    AST_XOFF_NO_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(xoff_held)); // R7
    AST_FULL_FLAGS_MATCH: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !fifo_empty && !(prio_full && prio_empty)); // R12

endmodule

// File: tb/sim_uart_tx_prio.sv
module sim_uart_tx_prio;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_wr = 1'b0, prio_wr = 1'b0;
    logic [7:0]  fifo_wdata = '0, prio_wdata = '0;
    logic [3:0]  frame_cfg = 4'b0001;
    logic [6:0]  line_ctl = 7'h01;
    logic [15:0] baud_div = '0;
    logic        cts = 1'b1, xoff_set = 1'b0, xoff_override = 1'b0;
    logic        txd, loop_out, dtr, rts, fifo_empty, shift_empty, drained;
    logic [7:0]  tx_count, prio_status;

    int total = 0, bad = 0;
    logic [7:0] expq[$];
    string sb_req = "R2";
    bit mon_en = 1, mon_loop = 0, mon_busy = 0;
    int bitlen = 10;

    always #10 clk = ~clk;

    uart_tx_prio u0 (
        .clk(clk), .rst(rst), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .prio_wr(prio_wr), .prio_wdata(prio_wdata), .frame_cfg(frame_cfg),
        .line_ctl(line_ctl), .baud_div(baud_div), .cts(cts),
        .xoff_set(xoff_set), .xoff_override(xoff_override), .txd(txd),
        .loop_out(loop_out), .dtr(dtr), .rts(rts), .tx_count(tx_count),
        .prio_status(prio_status), .fifo_empty(fifo_empty),
        .shift_empty(shift_empty), .drained(drained)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic mline();
        return mon_loop ? loop_out : txd;
    endfunction

    // Monitor: decodes the line and compares against the scoreboard queue.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && mline() == 1'b0) begin
                logic [7:0] d;
                logic [7:0] e;
                logic p;
                int nd;
                mon_busy = 1;
                d = '0;
                nd = frame_cfg[0] ? 8 : 7;
                repeat (bitlen / 2) @(negedge clk);
                chk(mline() == 1'b0, "R2", mline(), 0);
                for (int i = 0; i < nd; i++) begin
                    repeat (bitlen) @(negedge clk);
                    d[i] = mline();
                end
                if (frame_cfg[2]) begin
                    repeat (bitlen) @(negedge clk);
                    p = mline();
                    chk(p == (frame_cfg[1] ? ^d : ~^d), "R2", p, frame_cfg[1] ? ^d : ~^d);
                end
                for (int s = 0; s < (frame_cfg[3] ? 2 : 1); s++) begin
                    repeat (bitlen) @(negedge clk);
                    chk(mline() == 1'b1, "R2", mline(), 1);
                end
                if (expq.size() == 0) begin
                    chk(1'b0, sb_req, d, 'hFFF);
                end else begin
                    e = expq.pop_front();
                    chk(d == e, sb_req, d, e);
                end
                mon_busy = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic wr_fifo(logic [7:0] b);
        fifo_wr = 1'b1; fifo_wdata = b;
        @(negedge clk);
        fifo_wr = 1'b0;
    endtask

    task automatic wr_prio(logic [7:0] b);
        prio_wr = 1'b1; prio_wdata = b;
        @(negedge clk);
        prio_wr = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(drained && expq.size() == 0 && !mon_busy));
        repeat (20) @(negedge clk);
    endtask

    task automatic wait_sb();
        do @(negedge clk); while (!(expq.size() == 0 && !mon_busy && shift_empty));
        repeat (20) @(negedge clk);
    endtask

    task automatic wait_start();
        do @(negedge clk); while (txd != 1'b0);
    endtask

    initial begin
        int lowcnt;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1", txd, 1);
        chk(tx_count == 0 && prio_status == 0, "R1", {tx_count, prio_status}, 0);
        chk(fifo_empty && shift_empty && drained, "R1", {fifo_empty, shift_empty, drained}, 7);

        // R2 frame formats
        sb_req = "R2";
        foreach (expq[i]) ;
        wr_fifo(8'h55); expq.push_back(8'h55);
        wr_fifo(8'h80); expq.push_back(8'h80);
        wr_fifo(8'h0F); expq.push_back(8'h0F);
        wait_idle();
        frame_cfg = 4'b1111;                       // 8 data, even parity, 2 stop
        wr_fifo(8'h5A); expq.push_back(8'h5A);
        wr_fifo(8'hA5); expq.push_back(8'hA5);
        wr_fifo(8'h01); expq.push_back(8'h01);
        wait_idle();
        frame_cfg = 4'b0100;                       // 7 data, odd parity, 1 stop
        wr_fifo(8'hC3); expq.push_back(8'h43);
        wr_fifo(8'h7E); expq.push_back(8'h7E);
        wait_idle();
        frame_cfg = 4'b0001;

        // R3 bit time
        baud_div = 16'd2; bitlen = 30; mon_en = 0;
        wr_fifo(8'hFF);
        wait_start();
        lowcnt = 0;
        while (txd == 1'b0) begin lowcnt++; @(negedge clk); end
        chk(lowcnt == 30, "R3", lowcnt, 30);
        do @(negedge clk); while (!drained);
        repeat (40) @(negedge clk);
        mon_en = 1; sb_req = "R3";
        wr_fifo(8'h96); expq.push_back(8'h96);
        wait_idle();
        baud_div = 16'd0; bitlen = 10;

        // R4 urgent bytes overtake queued bytes at the next boundary
        sb_req = "R4";
        wr_fifo(8'hF0); wr_fifo(8'hF1); wr_fifo(8'hF2); wr_fifo(8'hF3);
        expq.push_back(8'hF0); expq.push_back(8'hF1);
        expq.push_back(8'hE0); expq.push_back(8'hE1);
        expq.push_back(8'hF2); expq.push_back(8'hF3);
        repeat (20) @(negedge clk);
        wr_prio(8'hE0); wr_prio(8'hE1);
        chk(prio_status == 8'h82, "R4", prio_status, 8'h82);
        wait_idle();
        chk(prio_status == 8'h00, "R4", prio_status, 0);
        // same-cycle write of both queues into an idle channel
        fifo_wr = 1'b1; fifo_wdata = 8'h11; prio_wr = 1'b1; prio_wdata = 8'h22;
        @(negedge clk);
        fifo_wr = 1'b0; prio_wr = 1'b0;
        expq.push_back(8'h22); expq.push_back(8'h11);
        wait_idle();

        // R5 transmit enable gates only the normal queue; R11 status
        sb_req = "R5";
        line_ctl = 7'h00;
        wr_fifo(8'h31); wr_fifo(8'h32); wr_fifo(8'h33);
        repeat (200) @(negedge clk);
        chk(tx_count == 3, "R5", tx_count, 3);
        chk(shift_empty == 1'b1 && txd == 1'b1, "R5", {shift_empty, txd}, 3);
        chk(fifo_empty == 1'b0 && drained == 1'b0, "R11", {fifo_empty, drained}, 0);
        wr_prio(8'h40); expq.push_back(8'h40);
        wait_sb();
        chk(tx_count == 3, "R5", tx_count, 3);
        line_ctl = 7'h01;
        expq.push_back(8'h31); expq.push_back(8'h32); expq.push_back(8'h33);
        wait_idle();
        chk(drained && fifo_empty && shift_empty, "R11", {fifo_empty, shift_empty, drained}, 7);
        wr_fifo(8'h51); wr_fifo(8'h52); wr_fifo(8'h53); wr_fifo(8'h54);
        expq.push_back(8'h51); expq.push_back(8'h52);
        wait_start();
        repeat (3) @(negedge clk);
        line_ctl = 7'h00;
        wait_sb();
        chk(tx_count == 2, "R5", tx_count, 2);
        line_ctl = 7'h01;
        expq.push_back(8'h53); expq.push_back(8'h54);
        wait_idle();

        // R6 CTS flow control
        sb_req = "R6";
        line_ctl = 7'h41; cts = 1'b0;
        wr_fifo(8'h61); expq.push_back(8'h61);
        repeat (300) @(negedge clk);
        chk(expq.size() == 1 && shift_empty == 1'b0, "R6", expq.size(), 1);
        cts = 1'b1;
        wait_idle();
        wr_fifo(8'h71); wr_fifo(8'h72);
        expq.push_back(8'h71); expq.push_back(8'h72);
        wait_start();
        repeat (3) @(negedge clk);
        cts = 1'b0;
        repeat (300) @(negedge clk);
        chk(expq.size() == 1, "R6", expq.size(), 1);
        cts = 1'b1;
        wait_idle();
        line_ctl = 7'h01;

        // R7 software hold-off and override
        sb_req = "R7";
        xoff_set = 1'b1; @(negedge clk); xoff_set = 1'b0;
        wr_fifo(8'h81); expq.push_back(8'h81);
        repeat (300) @(negedge clk);
        chk(expq.size() == 1 && txd == 1'b1, "R7", expq.size(), 1);
        xoff_override = 1'b1; @(negedge clk); xoff_override = 1'b0;
        wait_idle();

        // R8 break
        mon_en = 0;
        line_ctl = 7'h11;
        repeat (5) @(negedge clk);
        chk(txd == 1'b0, "R8", txd, 0);
        line_ctl = 7'h01;
        repeat (5) @(negedge clk);
        chk(txd == 1'b1, "R8", txd, 1);
        mon_en = 1;

        // R9 loopback
        sb_req = "R9";
        mon_loop = 1; line_ctl = 7'h09;
        wr_fifo(8'h9C); expq.push_back(8'h9C);
        lowcnt = 0;
        do begin
            @(negedge clk);
            if (txd == 1'b0) lowcnt++;
        end while (!(drained && expq.size() == 0 && !mon_busy));
        chk(lowcnt == 0, "R9", lowcnt, 0);
        repeat (20) @(negedge clk);
        mon_loop = 0; line_ctl = 7'h01;
        @(negedge clk);
        chk(loop_out == 1'b1, "R9", loop_out, 1);

        // R10 DTR / RTS
        sb_req = "R10";
        line_ctl = 7'h07;
        @(negedge clk);
        chk(dtr == 1'b1 && rts == 1'b1, "R10", {dtr, rts}, 3);
        line_ctl = 7'h01;
        @(negedge clk);
        chk(dtr == 1'b0 && rts == 1'b0, "R10", {dtr, rts}, 0);
        line_ctl = 7'h23;
        @(negedge clk);
        chk(rts == 1'b0, "R10", rts, 0);
        wr_fifo(8'hA1); expq.push_back(8'hA1);
        repeat (2) @(negedge clk);
        chk(rts == 1'b1, "R10", rts, 1);
        wait_idle();
        chk(rts == 1'b0, "R10", rts, 0);
        line_ctl = 7'h01;

        // R12 full queues drop writes
        sb_req = "R12";
        line_ctl = 7'h00;
        for (int i = 0; i < 256; i++) begin
            wr_fifo(8'(i));
            if (i < 255) expq.push_back(8'(i));
        end
        chk(tx_count == 8'd255, "R12", tx_count, 255);
        line_ctl = 7'h01;
        wait_idle();
        line_ctl = 7'h41; cts = 1'b0;
        for (int i = 0; i < 34; i++) begin
            wr_prio(8'(8'hC0 + i));
            if (i < 33) expq.push_back(8'(8'hC0 + i));
        end
        chk(prio_status == 8'hA0, "R12", prio_status, 8'hA0);
        cts = 1'b1;
        wait_idle();
        line_ctl = 7'h01;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule